// File: doc/BRIEF.md
# Timer Output Compare Unit

This block pairs a 16-bit up-counting timer with a 16-bit compare register and a single equality comparator. Whenever the timer reaches the compare value, a 4-bit mode field chooses the action. It can set the output latch high, clear it low, or invert it. It can raise only the interrupt flag. Or it can fire a trigger strobe that clears the timer, which turns the compare register into a programmable period.

Software loads the mode and the two compare bytes through a byte-wide write port. The timer advances on each cycle in which the increment enable is high. It runs on the same clock as the comparator, so the comparison stays exact. The trigger strobe can also start an analog-to-digital conversion, but only while the converter is flagged as enabled. The output latch reaches the pad through an output enable.

Top module: `ocu_top`

## Requirements
- R1: Write port: `wr_sel`=0 loads the mode from `wr_data[3:0]`, `wr_sel`=1 loads the compare low byte, `wr_sel`=2 loads the compare high byte. Each takes effect on the next clock edge. The timer adds one on each edge where `tmr_inc` is high and wraps at 16 bits.
- R2: Mode 4'b1000: the cycle after `tmr_val` first equals the compare value, `cmp_out` is 1.
- R3: Mode 4'b1001: the cycle after a match, `cmp_out` is 0.
- R4: Mode 4'b0010: the cycle after a match, `cmp_out` is inverted.
- R5: Mode 4'b1010: a match sets `irq_flag` and leaves `cmp_out` unchanged.
- R6: Mode 4'b1011: on a match the timer is cleared to zero, in the same cycle that `evt_trig` pulses high for exactly one cycle. With free counting, triggers therefore repeat every compare+1 cycles, and `cmp_out` is unchanged.
- R7: `adc_start` pulses together with `evt_trig` only when `adc_en` is high at the match. Otherwise it stays 0.
- R8: Modes 1000, 1001, 0010, 1010 and 1011 set `irq_flag` on a match, one cycle after the timer shows the compare value. The flag holds until `irq_clr`. When `irq_clr` and a match fall in the same cycle, the flag ends up set.
- R9: Writing mode 4'b0000 forces `cmp_out` to 0 on the next cycle. Mode 0000 and every code not listed above take no action on a match and do not set `irq_flag`.
- R10: A match acts once per arrival of the timer at the compare value. While the timer is held at that value, no further action occurs.
- R11: `pad_oe` follows `pin_out_sel`. `pad_do` carries `cmp_out` when `pad_oe` is 1 and is 0 when the pad is released.
- R12: After reset, the timer, compare value, mode, `cmp_out`, `irq_flag`, `evt_trig` and `adc_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by timer and comparator |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 compare low, 2 compare high |
| wr_data | input | 8 | Write data |
| tmr_inc | input | 1 | Timer increment enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| adc_en | input | 1 | Converter enabled; gates the conversion start |
| pin_out_sel | input | 1 | 1 drives the pad, 0 releases it |
| tmr_val | output | 16 | Current timer value |
| cmp_out | output | 1 | Compare output latch |
| pad_oe | output | 1 | Pad driver enable |
| pad_do | output | 1 | Pad data |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| evt_trig | output | 1 | One-cycle special event strobe |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
A stale equality history bit shows up the cycle after the timer reaches the compare value. Either the latch fails to move, or it keeps toggling while the timer is held. A corrupted mode or compare byte shows within one timer period as a latch, flag or trigger arriving at the wrong count. A trigger that fails to clear the timer shows as a period other than compare+1 between strobes. A flag that loses its set-over-clear priority reads 0 on the very next cycle.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam logic [3:0] MODE_OFF    = 4'b0000;
    localparam logic [3:0] MODE_TOGGLE = 4'b0010;
    localparam logic [3:0] MODE_SET    = 4'b1000;
    localparam logic [3:0] MODE_CLR    = 4'b1001;
    localparam logic [3:0] MODE_SWINT  = 4'b1010;
    localparam logic [3:0] MODE_TRIG   = 4'b1011;

    typedef struct packed {
        logic eq;
        logic latch;
        logic irq;
        logic trig;
        logic adc;
    } act_state_t;

    function automatic logic is_cmp_mode(input logic [3:0] m);
        return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR) ||
               (m == MODE_SWINT) || (m == MODE_TRIG);
    endfunction
endpackage

// File: rtl/ocu_regs.sv
module ocu_regs #(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NB = TW / BW,
    localparam int SELW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [BW-1:0]   wr_data,
    output logic [3:0]      mode_q,
    output logic [TW-1:0]   cmp_q,
    output logic            mode_zero_wr
);
    typedef struct packed {
        logic [3:0]    mode;
        logic [TW-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        mode_zero_wr = 1'b0;
        if (wr_en) begin
            if (wr_sel == '0) begin
                r_d.mode = wr_data[3:0];
                mode_zero_wr = (wr_data[3:0] == 4'b0000);
            end
            for (int b = 0; b < NB; b++) begin
                if (wr_sel == SELW'(b + 1)) r_d.cmp[b*BW +: BW] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_q = r_q.mode;
    assign cmp_q  = r_q.cmp;
endmodule

// File: rtl/ocu_timer.sv
module ocu_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [TW-1:0] tmr_q
);
    logic [TW-1:0] tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (clr)      tmr_d = '0;
        else if (inc) tmr_d = tmr_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/ocu_action.sv
module ocu_action
    import ocu_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode,
    input  logic [TW-1:0] cmp,
    input  logic [TW-1:0] tmr,
    input  logic          mode_zero_wr,
    input  logic          irq_clr,
    input  logic          adc_en,
    output logic          tmr_clr,
    output logic          latch,
    output logic          irq,
    output logic          trig,
    output logic          adc
);
    act_state_t s_d, s_q;
    logic eq, hit;

    always_comb begin
        eq      = (tmr == cmp);
        hit     = eq && !s_q.eq;
        tmr_clr = hit && (mode == MODE_TRIG);

        s_d     = s_q;
        s_d.eq  = eq;
        if (hit) begin
            case (mode)
                MODE_SET:    s_d.latch = 1'b1;
                MODE_CLR:    s_d.latch = 1'b0;
                MODE_TOGGLE: s_d.latch = !s_q.latch;
                default:     s_d.latch = s_q.latch;
            endcase
        end
        if (mode_zero_wr) s_d.latch = 1'b0;

        s_d.irq  = (s_q.irq && !irq_clr) || (hit && is_cmp_mode(mode));
        s_d.trig = tmr_clr;
        s_d.adc  = tmr_clr && adc_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign latch = s_q.latch;
    assign irq   = s_q.irq;
    assign trig  = s_q.trig;
    assign adc   = s_q.adc;
endmodule

// File: rtl/ocu_top.sv
module ocu_top #(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int SELW = $clog2(TW / BW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  logic [BW-1:0]   wr_data,
    input  logic            tmr_inc,
    input  logic            irq_clr,
    input  logic            adc_en,
    input  logic            pin_out_sel,
    output logic [TW-1:0]   tmr_val,
    output logic            cmp_out,
    output logic            pad_oe,
    output logic            pad_do,
    output logic            irq_flag,
    output logic            evt_trig,
    output logic            adc_start
);
    logic [3:0]    mode;
    logic [TW-1:0] cmp;
    logic          mode_zero_wr;
    logic          tmr_clr;

    ocu_regs #(.TW(TW), .BW(BW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mode_q(mode), .cmp_q(cmp),
        .mode_zero_wr(mode_zero_wr)
    );

    ocu_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .inc(tmr_inc), .clr(tmr_clr), .tmr_q(tmr_val)
    );

    ocu_action #(.TW(TW)) i_action (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cmp(cmp), .tmr(tmr_val),
        .mode_zero_wr(mode_zero_wr), .irq_clr(irq_clr), .adc_en(adc_en),
        .tmr_clr(tmr_clr), .latch(cmp_out), .irq(irq_flag),
        .trig(evt_trig), .adc(adc_start)
    );

    assign pad_oe = pin_out_sel;
    assign pad_do = pin_out_sel && cmp_out;
endmodule

// File: rtl/ocu_checker.sv
module ocu_checker #(
    parameter int TW = 16,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [SELW-1:0] wr_sel,
    input logic [3:0]      mode_data,
    input logic            irq_clr,
    input logic [TW-1:0]   tmr_val,
    input logic            cmp_out,
    input logic            irq_flag,
    input logic            evt_trig,
    input logic            adc_start
);
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    a_r6_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |=> !evt_trig);

    a_r6_trig_zero_timer: assert property (@(posedge clk) disable iff (!rst_n)
        evt_trig |-> (tmr_val == '0));

    a_r7_adc_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> evt_trig);

    a_r9_off_write_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0 && mode_data == 4'b0000) |=> !cmp_out);

    a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$past(wr_en) && $stable(tmr_val)) |=> $stable(cmp_out));
endmodule

bind ocu_top ocu_checker #(.TW(TW), .SELW(SELW)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .mode_data(wr_data[3:0]), .irq_clr(irq_clr), .tmr_val(tmr_val),
    .cmp_out(cmp_out), .irq_flag(irq_flag), .evt_trig(evt_trig),
    .adc_start(adc_start)
);

// File: tb/test_ocu_top.sv
module test_ocu_top;
    localparam int CLK_P = 10;
    localparam int NV = 7;
    localparam int WDOG = 150000;

    localparam logic [3:0]  V_MODE [NV] = '{4'b1000, 4'b1010, 4'b1001, 4'b0010, 4'b0010, 4'b1011, 4'b0101};
    localparam logic [15:0] V_CMP  [NV] = '{16'd3, 16'd6, 16'd9, 16'd12, 16'd20, 16'd25, 16'd4};
    localparam logic        V_PIN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic        V_IRQ  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic        V_TRIG [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] V_TMR  [NV] = '{16'd3, 16'd6, 16'd9, 16'd12, 16'd20, 16'd0, 16'd4};
    localparam string       V_REQ  [NV] = '{"R2", "R5", "R3", "R4", "R4", "R6", "R9"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic tmr_inc = 1'b0, irq_clr = 1'b0, adc_en = 1'b0, pin_out_sel = 1'b1;
    logic [15:0] tmr_val;
    logic cmp_out, pad_oe, pad_do, irq_flag, evt_trig, adc_start;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    ocu_top i_ocu_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tmr_inc(tmr_inc), .irq_clr(irq_clr),
        .adc_en(adc_en), .pin_out_sel(pin_out_sel), .tmr_val(tmr_val),
        .cmp_out(cmp_out), .pad_oe(pad_oe), .pad_do(pad_do),
        .irq_flag(irq_flag), .evt_trig(evt_trig), .adc_start(adc_start)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_cmp(input logic [15:0] v);
        wr(2'd1, v[7:0]);
        wr(2'd2, v[15:8]);
    endtask

    task automatic run_to(input logic [15:0] v);
        tmr_inc = 1'b1;
        while (tmr_val != v) tick();
        tmr_inc = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        int last_trig;
        int trig_seen;
        logic [15:0] max_tmr;

        do_reset();
        // R12 reset state
        chk("R12 tmr", tmr_val, 0);
        chk("R12 out", cmp_out, 0);
        chk("R12 irq", irq_flag, 0);
        chk("R12 trig", evt_trig, 0);
        chk("R12 adc", adc_start, 0);

        // R1 table walk: each entry writes compare then mode, runs to match
        for (int i = 0; i < NV; i++) begin
            set_cmp(V_CMP[i]);
            wr(2'd0, {4'b0000, V_MODE[i]});
            run_to(V_CMP[i]);
            tick();
            chk({V_REQ[i], " pin"}, cmp_out, V_PIN[i]);
            chk({"R8 irq ", V_REQ[i]}, irq_flag, V_IRQ[i]);
            chk({"R6 trig ", V_REQ[i]}, evt_trig, V_TRIG[i]);
            chk({"R7 adc gated ", V_REQ[i]}, adc_start, 0);
            chk({"R1 tmr ", V_REQ[i]}, tmr_val, V_TMR[i]);
            tick();
            chk("R6 trig single", evt_trig, 0);
            chk("R8 irq holds", irq_flag, V_IRQ[i]);
            irq_clr = 1'b1; tick(); irq_clr = 1'b0;
            chk("R8 irq cleared", irq_flag, 0);
        end

        // R2 then R9: set high, then off write forces low
        set_cmp(16'd10);
        wr(2'd0, 8'h08);
        run_to(16'd10);
        tick();
        chk("R2 set high", cmp_out, 1);
        wr(2'd0, 8'h00);
        chk("R9 off forces low", cmp_out, 0);

        // R10 toggle with timer held at match
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        set_cmp(16'd15);
        wr(2'd0, 8'h02);
        run_to(16'd15);
        tick();
        chk("R4 toggle", cmp_out, 1);
        for (int k = 0; k < 5; k++) tick();
        chk("R10 no repeat", cmp_out, 1);
        chk("R10 tmr held", tmr_val, 15);

        // R8 clear coincident with match
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R8 pre-clear", irq_flag, 0);
        set_cmp(16'd18);
        run_to(16'd18);
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        chk("R8 set beats clear", irq_flag, 1);

        // R6/R7 period with free-running timer and converter enabled
        do_reset();
        adc_en = 1'b1;
        set_cmp(16'd3);
        wr(2'd0, 8'h0B);
        tmr_inc = 1'b1;
        last_trig = -1;
        trig_seen = 0;
        max_tmr = '0;
        for (int c = 0; c < 24; c++) begin
            tick();
            if (tmr_val > max_tmr) max_tmr = tmr_val;
            if (evt_trig) begin
                chk("R7 adc with trig", adc_start, 1);
                if (last_trig >= 0) chk("R6 period", c - last_trig, 4);
                last_trig = c;
                trig_seen++;
            end else begin
                chk("R7 adc idle", adc_start, 0);
            end
        end
        tmr_inc = 1'b0;
        adc_en = 1'b0;
        chk("R6 trig count", trig_seen, 6);
        chk("R6 timer bound", max_tmr, 3);
        chk("R6 latch kept", cmp_out, 0);

        // R11 pad enable
        do_reset();
        set_cmp(16'd2);
        wr(2'd0, 8'h08);
        run_to(16'd2);
        tick();
        chk("R2 latch", cmp_out, 1);
        chk("R11 driven", {pad_oe, pad_do}, 2'b11);
        pin_out_sel = 1'b0;
        #1;
        chk("R11 released", {pad_oe, pad_do}, 2'b00);
        pin_out_sel = 1'b1;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule